// File: doc/BRIEF.md
# Interprocessor and interval timer interrupt register

This block holds one 64-bit control word shared by four CPUs, plus one interval ignore counter for each CPU. Software reaches both through a single-cycle 64-bit register port. The control word carries several kinds of field:

- a timer interrupt bit for each CPU;
- an interprocessor interrupt bit for each CPU, raised through a separate request field;
- an arbitration pair of nibbles, with a clear command and a set rule that depends on the current value;
- a plain read/write nibble;
- a fixed revision bit.

Each field follows its own write rule, so a single store can clear some bits, set others and replace the rest.

An external timer line supplies ticks. On each rising edge of that line, every ignore counter decrements. Once a counter has passed below zero, its sticky overflow bit is set, and from then on every tick raises that CPU's timer interrupt bit until software clears it. Software delays timer interrupts for a CPU by loading its counter with the number of ticks to skip. Software can later read the counter to learn how many ticks went by.

The block drives eight outputs: four interprocessor interrupt lines and four timer interrupt lines. Each line is a direct copy of its bit in the control word.

Top module: `ipt_irq_ctl`

## Requirements
- R1: After reset, the control word reads as 0x0000_0008_0000_0000 (bit 35 set) OR the accessor index, every ignore counter reads 0, and all interrupt outputs are 0.
- R2: A write to offset 0x080 clears each bit of the control word at which the written value has a 1 under mask 0x1000_0FF0 (timer bits [7:4], interprocessor bits [11:8], bit 28).
- R3: In a write to 0x080 with data bit 20 equal to 1, bits [23:16] are cleared. In a write with data bit 20 equal to 0, data bits [23:20] are OR-ed into bits [23:20], and data bits [19:16] are OR-ed into bits [19:16] only if bits [19:16] were all zero.
- R4: Data bits [15:12] of a write to 0x080 are OR-ed into bits [11:8], so data bit 12+i raises interprocessor bit 8+i. This set is applied after the clear of R2.
- R5: Bits [43:40] of the control word take the written value. The other bits not named in R2 to R4 (including bit 35) are never changed by a write.
- R6: A read presents its data on `rdata` in the cycle after `rd_en`. A read of 0x080 returns the control word OR-ed with `cpu_id` in bits [1:0].
- R7: `ipi_o[i]` equals control bit 8+i and `timer_irq_o[i]` equals control bit 4+i.
- R8: A write to the counter of CPU i (offsets 0x380, 0x3C0, 0x700, 0x740 for i = 0 to 3) stores data bits [23:0] and clears overflow bit 24. A read returns the 25-bit counter, zero-extended.
- R9: Only a low-to-high transition of `tick_in` is a tick. Holding the line high or dropping it does nothing. On a tick, each counter becomes ((count - 1) mod 2^25) with bit 24 OR-ed with its previous value.
- R10: On a tick, if counter i holds bit 24 after its update, control bit 4+i is set.
- R11: If a write to counter i and a tick happen in the same cycle, the write wins, and that tick sets no timer bit for CPU i.
- R12: If a tick sets timer bit 4+i in the same cycle as a write to 0x080 that clears it, the bit ends up set.
- R13: A read of any other offset returns all ones, with `rd_err` high for that one data cycle. `rd_err` is 0 after mapped reads. A write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 64 | Write data |
| cpu_id | input | 2 | Index of the CPU that makes the access |
| tick_in | input | 1 | Interval timer line; its rising edge is a tick |
| rdata | output | 64 | Read data, valid the cycle after `rd_en` |
| rd_err | output | 1 | High for one cycle after a read of an unmapped offset |
| ipi_o | output | 4 | Interprocessor interrupt for each CPU |
| timer_irq_o | output | 4 | Interval timer interrupt for each CPU |

## Verification
The bench sweeps all sixteen request patterns and checks that each one reaches the interprocessor outputs and is removed again by a clear write. A design that applied the clear after the set would lose requests written together with a clear.

It loads the counters with small values, so that the wrap through zero and the sticky overflow both happen within a few ticks. A counter that cleared its overflow on the next decrement would stop raising timer interrupts. The same part of the sweep holds the tick line high and drops it, to catch a design that decrements on the level instead of the edge.

It drives a counter write together with a tick, and a timer clear together with a tick, to catch the wrong winner in each collision. It runs the arbitration nibble through its set-only-if-zero rule, so a design that ORs unconditionally shows a merged value. It also reads and writes unmapped offsets, which a loose decoder would alias onto a real register.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    localparam int NCPU   = 4;
    localparam int DW     = 64;
    localparam int AW     = 12;

    // control word field positions
    localparam int TMR_LO  = 4;
    localparam int IPI_LO  = 8;
    localparam int REQ_LO  = 12;
    localparam int LOCK_LO = 16;
    localparam int FLAG_LO = 20;
    localparam int CLR_BIT = 20;
    localparam int USR_LO  = 40;

    localparam logic [DW-1:0] W1C_MASK  = 64'h0000_0000_1000_0FF0;
    localparam logic [DW-1:0] RESET_VAL = 64'h0000_0008_0000_0000;

    localparam logic [AW-1:0] OFF_CTRL = 12'h080;

    function automatic logic [AW-1:0] cnt_off(input int idx);
        case (idx)
            0:       return 12'h380;
            1:       return 12'h3C0;
            2:       return 12'h700;
            default: return 12'h740;
        endcase
    endfunction

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          rd_err;
        logic          tick_prev;
    } port_st_t;

endpackage

// File: rtl/ipt_addr_dec.sv
module ipt_addr_dec
    import ipt_pkg::*;
(
    input  logic [AW-1:0]   addr,
    output logic            hit_ctrl,
    output logic [NCPU-1:0] hit_cnt,
    output logic            mapped
);

    assign hit_ctrl = (addr == OFF_CTRL);

    for (genvar g = 0; g < NCPU; g++) begin : g_cnt_hit
        assign hit_cnt[g] = (addr == cnt_off(g));
    end

    assign mapped = hit_ctrl | (|hit_cnt);

endmodule

// File: rtl/ipt_ign_cnt.sv
module ipt_ign_cnt #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    output logic [CNT_W:0]   cnt_q,
    output logic             ovf_set
);

    logic [CNT_W:0] cnt_d;
    logic [CNT_W:0] dec;

    always_comb begin
        dec     = cnt_q - 1'b1;
        cnt_d   = cnt_q;
        ovf_set = 1'b0;
        if (wr_en) begin
            cnt_d = {1'b0, wdata};
        end else if (tick) begin
            cnt_d   = {dec[CNT_W] | cnt_q[CNT_W], dec[CNT_W-1:0]};
            ovf_set = cnt_d[CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ipt_ctrl_word.sv
module ipt_ctrl_word
    import ipt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   wdata,
    input  logic [NCPU-1:0] tmr_set,
    output logic [DW-1:0]   ctrl_q
);

    logic [DW-1:0] ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d = ctrl_d & ~(wdata & W1C_MASK);
            if (wdata[CLR_BIT]) begin
                ctrl_d[LOCK_LO +: 8] = 8'h00;
            end else begin
                ctrl_d[FLAG_LO +: 4] = ctrl_d[FLAG_LO +: 4] | wdata[FLAG_LO +: 4];
                if (ctrl_q[LOCK_LO +: 4] == 4'h0)
                    ctrl_d[LOCK_LO +: 4] = wdata[LOCK_LO +: 4];
            end
            ctrl_d[IPI_LO +: NCPU] = ctrl_d[IPI_LO +: NCPU] | wdata[REQ_LO +: NCPU];
            ctrl_d[USR_LO +: 4]    = wdata[USR_LO +: 4];
        end
        // tick-driven set wins over a same-cycle clear
        ctrl_d[TMR_LO +: NCPU] = ctrl_d[TMR_LO +: NCPU] | tmr_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= RESET_VAL;
        else        ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/ipt_irq_ctl.sv
module ipt_irq_ctl
    import ipt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [11:0]     addr,
    input  logic [63:0]     wdata,
    input  logic [1:0]      cpu_id,
    input  logic            tick_in,
    output logic [63:0]     rdata,
    output logic            rd_err,
    output logic [3:0]      ipi_o,
    output logic [3:0]      timer_irq_o
);

    localparam int PAD_W = DW - CNT_W - 1;

    port_st_t st_d, st_q;

    logic            hit_ctrl, mapped;
    logic [NCPU-1:0] hit_cnt;
    logic            tick_evt;
    logic [NCPU-1:0] tmr_set;
    logic [DW-1:0]   ctrl_q;
    logic [CNT_W:0]  cnt_q [NCPU];
    logic [DW-1:0]   rd_mux;

    assign tick_evt = tick_in & ~st_q.tick_prev;

    ipt_addr_dec u_dec (
        .addr     (addr),
        .hit_ctrl (hit_ctrl),
        .hit_cnt  (hit_cnt),
        .mapped   (mapped)
    );

    for (genvar g = 0; g < NCPU; g++) begin : g_cnt
        ipt_ign_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en & hit_cnt[g]),
            .wdata   (wdata[CNT_W-1:0]),
            .tick    (tick_evt),
            .cnt_q   (cnt_q[g]),
            .ovf_set (tmr_set[g])
        );
    end

    ipt_ctrl_word u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en & hit_ctrl),
        .wdata   (wdata),
        .tmr_set (tmr_set),
        .ctrl_q  (ctrl_q)
    );

    always_comb begin
        rd_mux = '1;
        if (hit_ctrl) rd_mux = ctrl_q | {{(DW-2){1'b0}}, cpu_id};
        for (int i = 0; i < NCPU; i++) begin
            if (hit_cnt[i]) rd_mux = {{PAD_W{1'b0}}, cnt_q[i]};
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.tick_prev = tick_in;
        if (rd_en) begin
            st_d.rdata  = rd_mux;
            st_d.rd_err = ~mapped;
        end else begin
            st_d.rd_err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata       = st_q.rdata;
    assign rd_err      = st_q.rd_err;
    assign ipi_o       = ctrl_q[IPI_LO +: NCPU];
    assign timer_irq_o = ctrl_q[TMR_LO +: NCPU];

endmodule

// File: rtl/ipt_irq_chk.sv
module ipt_irq_chk
    import ipt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [11:0] addr,
    input logic [63:0] rdata,
    input logic        rd_err,
    input logic [3:0]  ipi_o,
    input logic [3:0]  timer_irq_o,
    input logic        tick_evt
);

    a_r13_err_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rdata == '1));

    a_r13_err_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> $past(rd_en));

    a_r4_ipi_rise_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((ipi_o & ~$past(ipi_o)) != 4'h0) |-> $past(wr_en && addr == OFF_CTRL));

    a_r10_tmr_rise_by_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ((timer_irq_o & ~$past(timer_irq_o)) != 4'h0) |-> $past(tick_evt));

    a_r7_tmr_fall_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((~timer_irq_o & $past(timer_irq_o)) != 4'h0) |-> $past(wr_en && addr == OFF_CTRL));

    a_r9_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt |=> !tick_evt);

endmodule

bind ipt_irq_ctl ipt_irq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .rdata       (rdata),
    .rd_err      (rd_err),
    .ipi_o       (ipi_o),
    .timer_irq_o (timer_irq_o),
    .tick_evt    (tick_evt)
);

// File: tb/tb_ipt_irq_ctl.sv
`timescale 1ns/1ps
module tb_ipt_irq_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [1:0]  cpu_id = '0;
    logic        tick_in = 1'b0;
    logic [63:0] rdata;
    logic        rd_err;
    logic [3:0]  ipi_o;
    logic [3:0]  timer_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_ctrl;
    logic [24:0] m_cnt [4];
    logic        m_lvl;

    localparam logic [11:0] A_CTRL = 12'h080;
    localparam logic [11:0] A_C0 = 12'h380, A_C1 = 12'h3C0, A_C2 = 12'h700, A_C3 = 12'h740;

    always #10 clk = ~clk;

    ipt_irq_ctl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .cpu_id(cpu_id), .tick_in(tick_in), .rdata(rdata),
        .rd_err(rd_err), .ipi_o(ipi_o), .timer_irq_o(timer_irq_o)
    );

    function automatic logic [11:0] caddr(input int i);
        case (i)
            0: return A_C0;
            1: return A_C1;
            2: return A_C2;
            default: return A_C3;
        endcase
    endfunction

    function automatic logic [63:0] ctrl_wr(input logic [63:0] o, input logic [63:0] w);
        logic [63:0] n;
        n = o & ~(w & 64'h1000_0FF0);
        if (w[20]) n[23:16] = 8'h00;
        else begin
            n[23:20] = n[23:20] | w[23:20];
            if (o[19:16] == 4'h0) n[19:16] = w[19:16];
        end
        n[11:8] = n[11:8] | w[15:12];
        n[43:40] = w[43:40];
        return n;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: optional write, tick line level; returns at a negedge
    task automatic cyc(input bit we, input logic [11:0] a, input logic [63:0] d, input bit tk);
        logic [3:0] setv;
        bit rise;
        wr_en = we; addr = a; wdata = d; tick_in = tk;
        @(posedge clk);
        rise = tk && !m_lvl;
        m_lvl = tk;
        setv = 4'h0;
        for (int i = 0; i < 4; i++) begin
            if (we && a == caddr(i)) m_cnt[i] = {1'b0, d[23:0]};
            else if (rise) begin
                m_cnt[i] = ((m_cnt[i] - 25'd1) & 25'h1FF_FFFF) | (m_cnt[i] & 25'h100_0000);
                setv[i] = m_cnt[i][24];
            end
        end
        if (we && a == A_CTRL) m_ctrl = ctrl_wr(m_ctrl, d);
        m_ctrl[7:4] = m_ctrl[7:4] | setv;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] id, output logic [63:0] v, output logic e);
        rd_en = 1'b1; addr = a; cpu_id = id;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata; e = rd_err;
    endtask

    task automatic chk_out(input string req);
        check(req, {56'h0, ipi_o, timer_irq_o}, {56'h0, m_ctrl[11:8], m_ctrl[7:4]});
    endtask

    task automatic chk_ctrl(input string req, input logic [1:0] id);
        logic [63:0] v; logic e;
        rd(A_CTRL, id, v, e);
        check(req, v, m_ctrl | {62'h0, id});
        check({req, " rd_err"}, {63'h0, e}, 64'h0);
    endtask

    task automatic chk_cnt(input string req, input int i);
        logic [63:0] v; logic e;
        rd(caddr(i), 2'd0, v, e);
        check(req, v, {39'h0, m_cnt[i]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] v; logic e;
        m_ctrl = 64'h0000_0008_0000_0000;
        for (int i = 0; i < 4; i++) m_cnt[i] = '0;
        m_lvl = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R6 accessor index on each cpu
        chk_out("R1 outputs");
        for (int id = 0; id < 4; id++) chk_ctrl("R1 R6 ctrl read", 2'(id));
        for (int i = 0; i < 4; i++) chk_cnt("R1 counter", i);

        // R4 request sweep, R2 clear, R7 outputs
        for (int k = 0; k < 16; k++) begin
            cyc(1, A_CTRL, {48'h0, 4'(k), 12'h000}, 0);
            chk_out("R4 R7 ipi request");
            cyc(1, A_CTRL, 64'h0000_0F00, 0);
            chk_out("R2 ipi clear");
        end
        // R4 set applied after R2 clear in same write
        cyc(1, A_CTRL, 64'h0000_5000, 0);
        cyc(1, A_CTRL, 64'h0000_AF00, 0);
        chk_out("R4 clear then set");
        chk_ctrl("R4 ctrl read", 2'd3);

        // R3 arbitration fields
        cyc(1, A_CTRL, 64'h00C3_0000, 0);
        chk_ctrl("R3 set both", 2'd1);
        cyc(1, A_CTRL, 64'h0025_0000, 0);
        chk_ctrl("R3 lock held when nonzero", 2'd2);
        cyc(1, A_CTRL, 64'h0010_0000, 0);
        chk_ctrl("R3 clear command", 2'd0);
        cyc(1, A_CTRL, 64'h0005_0000, 0);
        chk_ctrl("R3 lock set when zero", 2'd0);

        // R5 read/write nibble and protected bits; R2 bit 28
        cyc(1, A_CTRL, 64'h0000_0A00_1000_0000, 0);
        chk_ctrl("R5 user nibble", 2'd0);
        cyc(1, A_CTRL, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        chk_ctrl("R5 all ones write", 2'd2);
        chk_out("R7 after all ones");
        cyc(1, A_CTRL, 64'h0000_0000_0000_0F00, 0);
        chk_out("R2 clear all ipi");

        // R8 counter write and read-back
        for (int i = 0; i < 4; i++) begin
            cyc(1, caddr(i), 64'hFFFF_FFFF_FFAB_CDE0 | 64'(i), 0);
            chk_cnt("R8 counter store", i);
        end

        // R9 R10 tick sweep with small starting values
        for (int base = 0; base < 3; base++) begin
            for (int i = 0; i < 4; i++) cyc(1, caddr(i), 64'(base + i), 0);
            cyc(1, A_CTRL, 64'h0000_00F0, 0);
            for (int t = 0; t < 6; t++) begin
                cyc(0, 12'h000, 64'h0, 1);
                chk_out("R10 timer after tick");
                cyc(0, 12'h000, 64'h0, 1);
                chk_out("R9 level held");
                cyc(0, 12'h000, 64'h0, 0);
                chk_out("R9 falling edge");
                for (int i = 0; i < 4; i++) chk_cnt("R9 counter decrement", i);
                cyc(1, A_CTRL, 64'h0000_00F0, 0);
                chk_out("R2 timer clear");
            end
        end

        // R11 counter write collides with tick
        for (int i = 0; i < 4; i++) cyc(1, caddr(i), 64'h0, 0);
        cyc(1, A_CTRL, 64'h0000_00F0, 0);
        cyc(1, A_C2, 64'h0000_0007, 1);
        chk_out("R11 write wins no timer");
        chk_cnt("R11 written value kept", 2);
        chk_cnt("R11 other counter ticked", 0);
        cyc(0, 12'h000, 64'h0, 0);

        // R12 tick set beats same-cycle clear
        cyc(1, A_CTRL, 64'h0000_00F0, 1);
        chk_out("R12 set beats clear");
        chk_ctrl("R12 ctrl read", 2'd1);
        cyc(0, 12'h000, 64'h0, 0);

        // R13 unmapped accesses
        rd(12'h088, 2'd0, v, e);
        check("R13 unmapped data", v, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R13 unmapped err", {63'h0, e}, 64'h1);
        @(negedge clk);
        check("R13 err one cycle", {63'h0, rd_err}, 64'h0);
        rd(12'h384, 2'd0, v, e);
        check("R13 near-miss counter", {63'h0, e}, 64'h1);
        cyc(1, 12'h0C0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        cyc(1, 12'h081, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        chk_ctrl("R13 unmapped write ignored", 2'd0);
        for (int i = 0; i < 4; i++) chk_cnt("R13 counters untouched", i);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule